// File: doc/BRIEF.md
# Peripheral Streaming DMA Channel

This block is one DMA channel that carries 32-bit words between system memory and a single data register of a peripheral on an APB bus. Each word is a beat. On the memory side the address moves forward by one word after every beat, through a simple request/grant port. On the peripheral side every access goes to one fixed APB address. Beats are paced by a peripheral request line, which a 5-bit selector picks out of the request vector.

Software loads a descriptor with a one-cycle load strobe. The descriptor holds the direction, the mode, the request selector, the memory start address, the peripheral address and the length in words. If the channel is idle, the load starts a transfer at once. If the channel is busy, the load goes into a shadow slot instead, and that descriptor is taken over at the completion of the current one with no idle gap.

A one-shot transfer moves its length and stops. A streaming transfer also raises a threshold pulse when half of its buffer has been moved. An abort input ends the transfer at the next beat boundary.

Top module: `apb_dma_chan`

## Requirements
- R1: After reset, `busy` is 0, `status` is 0, `buf_status` is 0, `byte_count` is 0 and neither bus is driven. A load while idle sets `busy` to 1, `status` to 2 (in flight), `buf_status` to 0 (empty) and `byte_count` to 0 on the next cycle.
- R2: With `cfg_to_mem`=0, each beat reads memory at the start address plus 4 times the beat index (`mem_we`=0). It then writes that word on APB with `pwrite`=1 to the fixed peripheral address.
- R3: With `cfg_to_mem`=1, each beat reads the fixed peripheral address on APB (`pwrite`=0). It then writes the returned word to memory at the start address plus 4 times the beat index (`mem_we`=1).
- R4: Every APB access has exactly one setup cycle (`psel`=1, `penable`=0). The access phase follows (`psel`=1, `penable`=1) and holds, with `paddr` and `pwrite` stable, until `pready` is 1.
- R5: A beat starts only while the selected bit of `periph_req` is 1. Selector codes of `NUM_REQ` (26) or higher, including 31, never start a beat.
- R6: In one-shot mode (`cfg_stream`=0) exactly the programmed number of words moves. `irq_done` pulses for one cycle, then `busy` is 0, `status` is 0 (success) and `buf_status` is 2 (full). `irq_thresh` never pulses.
- R7: In streaming mode (`cfg_stream`=1), `irq_thresh` pulses once after floor(N/2) words of an N-word buffer and `buf_status` becomes 1 (half). `irq_done` pulses after N words.
- R8: A load while busy sets `next_armed`. At completion the channel continues with the shadow descriptor, with `busy` held at 1, its own addresses and length, and `byte_count` counting on. `next_armed` then clears.
- R9: An abort during a beat lets that beat finish; an abort between beats stops at once. Either way, `busy` goes to 0 and `status` to 1 (aborted). `byte_count` equals the bytes actually moved, no `irq_done` is raised, and `next_armed` is left unchanged.
- R10: An abort while the channel is idle has no effect on `status`, `busy` or `byte_count`.
- R11: `byte_count` grows by exactly 4 for each completed beat and never by any other step while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | One-cycle descriptor load strobe |
| cfg_to_mem | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| cfg_stream | input | 1 | 1: streaming mode with threshold, 0: one-shot |
| cfg_req_sel | input | 5 | Index of the pacing request line |
| cfg_mem_addr | input | 32 | Memory start address (word aligned) |
| cfg_apb_addr | input | 32 | Fixed peripheral register address |
| cfg_words | input | 16 | Transfer length in words (1 or more) |
| abort | input | 1 | Stop request |
| periph_req | input | 26 | Peripheral request lines |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant; access completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with grant |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pwrite | output | 1 | APB write |
| paddr | output | 32 | APB address |
| pwdata | output | 32 | APB write data |
| prdata | input | 32 | APB read data |
| pready | input | 1 | APB ready |
| busy | output | 1 | Transfer active |
| status | output | 2 | 0 success, 1 aborted, 2 in flight |
| buf_status | output | 2 | 0 empty, 1 half, 2 full |
| byte_count | output | 20 | Bytes moved since the last idle load |
| irq_done | output | 1 | One-cycle completion pulse |
| irq_thresh | output | 1 | One-cycle half-buffer pulse (streaming only) |
| next_armed | output | 1 | Shadow descriptor loaded |

## Verification
The bench targets the hand-over boundary. A design that dropped `busy` for a cycle, or that restarted at the old memory address, would show a gap or the wrong data words in the APB log. It also sends an abort in the middle of an APB wait: a design that cut the beat short would leave `byte_count` out of step with the words actually written, and one that cleared the shadow would drop `next_armed`. Pacing is checked with the selected line held low while all other lines are high, and with the invalid code 31. A wrong index would let beats through. The threshold is checked by recording how many words had moved when it fired, which catches an off-by-one in the half-point compare.

// File: rtl/apb_dma_pkg.sv
// Shared encodings for the APB DMA channel.
// Assumes: status and buffer codes are seen by software, so their values are fixed.
package apb_dma_pkg;

    typedef enum logic [1:0] {
        ST_SUCCESS  = 2'd0,
        ST_ABORTED  = 2'd1,
        ST_INFLIGHT = 2'd2
    } xfer_status_e;

    typedef enum logic [1:0] {
        BUF_EMPTY = 2'd0,
        BUF_HALF  = 2'd1,
        BUF_FULL  = 2'd2
    } buf_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_MEM,
        PH_SETUP,
        PH_ACCESS
    } beat_phase_e;

endpackage

// File: rtl/dma_desc_bank.sv
// Shadow descriptor slot. It holds the next descriptor while the channel is busy.
// Assumes: take_i is raised only at the completion of the active descriptor.
// A load in the same cycle as a take with an empty slot is forwarded straight through.
module dma_desc_bank #(
    parameter int DESC_W = 88
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              busy_i,
    input  logic              take_i,
    input  logic [DESC_W-1:0] cfg_i,
    output logic              armed_o,
    output logic              next_valid_o,
    output logic [DESC_W-1:0] next_o
);

    logic              valid_q;
    logic [DESC_W-1:0] slot_q;
    logic              pass_through;

    assign pass_through = take_i && !valid_q;

    // Capture loads made while busy; release the slot when it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            slot_q  <= '0;
        end else begin
            if (take_i) begin
                valid_q <= 1'b0;
            end
            if (load_i && busy_i && !pass_through) begin
                slot_q  <= cfg_i;
                valid_q <= 1'b1;
            end
        end
    end

    assign armed_o      = valid_q;
    assign next_valid_o = valid_q || (load_i && busy_i);
    assign next_o       = valid_q ? slot_q : cfg_i;

endmodule

// File: rtl/dma_beat_engine.sv
// Runs a single beat: one memory access and one APB access, ordered by direction.
// Assumes: the direction and both addresses stay stable while a beat is in progress.
module dma_beat_engine
    import apb_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic          to_mem_i,
    input  logic [AW-1:0] mem_addr_i,
    input  logic [AW-1:0] apb_addr_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic          mem_gnt_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          psel_o,
    output logic          penable_o,
    output logic          pwrite_o,
    output logic [AW-1:0] paddr_o,
    output logic [DW-1:0] pwdata_o,
    input  logic [DW-1:0] prdata_i,
    input  logic          pready_i,
    output logic          idle_o,
    output logic          beat_done_o
);

    beat_phase_e   ph_q;
    logic [DW-1:0] data_q;

    // Step through the beat phases and hold the word in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            data_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE:   if (go_i) ph_q <= to_mem_i ? PH_SETUP : PH_MEM;
                PH_MEM:    if (mem_gnt_i) begin
                               if (!to_mem_i) data_q <= mem_rdata_i;
                               ph_q <= to_mem_i ? PH_IDLE : PH_SETUP;
                           end
                PH_SETUP:  ph_q <= PH_ACCESS;
                PH_ACCESS: if (pready_i) begin
                               if (to_mem_i) data_q <= prdata_i;
                               ph_q <= to_mem_i ? PH_MEM : PH_IDLE;
                           end
                default:   ph_q <= PH_IDLE;
            endcase
        end
    end

    assign mem_req_o   = (ph_q == PH_MEM);
    assign mem_we_o    = to_mem_i;
    assign mem_addr_o  = mem_addr_i;
    assign mem_wdata_o = data_q;
    assign psel_o      = (ph_q == PH_SETUP) || (ph_q == PH_ACCESS);
    assign penable_o   = (ph_q == PH_ACCESS);
    assign pwrite_o    = !to_mem_i;
    assign paddr_o     = apb_addr_i;
    assign pwdata_o    = data_q;
    assign idle_o      = (ph_q == PH_IDLE);
    assign beat_done_o = ((ph_q == PH_MEM) && mem_gnt_i && to_mem_i) ||
                         ((ph_q == PH_ACCESS) && pready_i && !to_mem_i);

endmodule

// File: rtl/apb_dma_chan.sv
// Single DMA channel between a memory port and one fixed APB register.
// Holds the active descriptor, the counters, the mode events and the abort
// handling. Beats go to dma_beat_engine and the next descriptor to dma_desc_bank.
// Assumes: cfg_words >= 1 and NUM_REQ <= 2**SEL_W.
module apb_dma_chan
    import apb_dma_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int CNT_W   = 16,
    parameter int BC_W    = 20,
    parameter int SEL_W   = 5,
    parameter int NUM_REQ = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_to_mem,
    input  logic             cfg_stream,
    input  logic [SEL_W-1:0] cfg_req_sel,
    input  logic [AW-1:0]    cfg_mem_addr,
    input  logic [AW-1:0]    cfg_apb_addr,
    input  logic [CNT_W-1:0] cfg_words,
    input  logic             abort,
    input  logic [NUM_REQ-1:0] periph_req,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_gnt,
    input  logic [DW-1:0]    mem_rdata,
    output logic             psel,
    output logic             penable,
    output logic             pwrite,
    output logic [AW-1:0]    paddr,
    output logic [DW-1:0]    pwdata,
    input  logic [DW-1:0]    prdata,
    input  logic             pready,
    output logic             busy,
    output logic [1:0]       status,
    output logic [1:0]       buf_status,
    output logic [BC_W-1:0]  byte_count,
    output logic             irq_done,
    output logic             irq_thresh,
    output logic             next_armed
);

    localparam int ACT_W     = 2 + SEL_W + AW + CNT_W;
    localparam int DESC_W    = ACT_W + AW;
    localparam int REQ_SPACE = 2 ** SEL_W;
    localparam int BEAT_B    = DW / 8;

    logic [DESC_W-1:0] cfg_vec, next_desc;
    logic [ACT_W-1:0]  act_q;
    logic [AW-1:0]     mem_ptr_q;
    logic [CNT_W-1:0]  word_cnt_q, word_next;
    logic [BC_W-1:0]   bytes_q;
    xfer_status_e      status_q;
    buf_state_e        buf_q;
    logic              busy_q, abort_pend_q, done_q, thr_q;
    logic              eng_idle, beat_done, go, next_valid, take;
    logic              last_beat, thr_hit, req_ok;
    logic [REQ_SPACE-1:0] req_ext;

    logic [CNT_W-1:0] a_words;
    logic [AW-1:0]    a_paddr;
    logic [SEL_W-1:0] a_sel;
    logic             a_cont, a_dir;

    assign cfg_vec = {cfg_to_mem, cfg_stream, cfg_req_sel, cfg_apb_addr, cfg_words, cfg_mem_addr};
    assign a_words = act_q[CNT_W-1:0];
    assign a_paddr = act_q[CNT_W +: AW];
    assign a_sel   = act_q[CNT_W+AW +: SEL_W];
    assign a_cont  = act_q[ACT_W-2];
    assign a_dir   = act_q[ACT_W-1];

    assign req_ext   = REQ_SPACE'(periph_req);
    assign req_ok    = req_ext[a_sel];
    assign word_next = word_cnt_q + 1'b1;
    assign last_beat = (word_next == a_words);
    assign thr_hit   = a_cont && (word_next == (a_words >> 1));
    assign go        = busy_q && eng_idle && req_ok && !abort && !abort_pend_q;
    assign take      = beat_done && last_beat && !abort && !abort_pend_q;

    dma_desc_bank #(.DESC_W(DESC_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .load_i(cfg_load), .busy_i(busy_q),
        .take_i(take), .cfg_i(cfg_vec), .armed_o(next_armed),
        .next_valid_o(next_valid), .next_o(next_desc)
    );

    dma_beat_engine #(.AW(AW), .DW(DW)) eng_i (
        .clk(clk), .rst_n(rst_n), .go_i(go), .to_mem_i(a_dir),
        .mem_addr_i(mem_ptr_q), .apb_addr_i(a_paddr),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata),
        .psel_o(psel), .penable_o(penable), .pwrite_o(pwrite), .paddr_o(paddr),
        .pwdata_o(pwdata), .prdata_i(prdata), .pready_i(pready),
        .idle_o(eng_idle), .beat_done_o(beat_done)
    );

    // Channel control: start, beat accounting, mode events, hand-over and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q        <= '0;
            mem_ptr_q    <= '0;
            word_cnt_q   <= '0;
            bytes_q      <= '0;
            status_q     <= ST_SUCCESS;
            buf_q        <= BUF_EMPTY;
            busy_q       <= 1'b0;
            abort_pend_q <= 1'b0;
            done_q       <= 1'b0;
            thr_q        <= 1'b0;
        end else begin
            done_q <= 1'b0;
            thr_q  <= 1'b0;
            if (!busy_q) begin
                if (cfg_load) begin
                    act_q        <= cfg_vec[DESC_W-1:AW];
                    mem_ptr_q    <= cfg_mem_addr;
                    word_cnt_q   <= '0;
                    bytes_q      <= '0;
                    busy_q       <= 1'b1;
                    status_q     <= ST_INFLIGHT;
                    buf_q        <= BUF_EMPTY;
                    abort_pend_q <= 1'b0;
                end
            end else if (abort && eng_idle) begin
                busy_q       <= 1'b0;
                status_q     <= ST_ABORTED;
                abort_pend_q <= 1'b0;
            end else begin
                if (abort) abort_pend_q <= 1'b1;
                if (beat_done) begin
                    bytes_q    <= bytes_q + BC_W'(BEAT_B);
                    mem_ptr_q  <= mem_ptr_q + AW'(BEAT_B);
                    word_cnt_q <= word_next;
                    if (abort || abort_pend_q) begin
                        busy_q       <= 1'b0;
                        status_q     <= ST_ABORTED;
                        abort_pend_q <= 1'b0;
                    end else if (last_beat) begin
                        done_q <= 1'b1;
                        if (next_valid) begin
                            act_q      <= next_desc[DESC_W-1:AW];
                            mem_ptr_q  <= next_desc[AW-1:0];
                            word_cnt_q <= '0;
                            buf_q      <= BUF_EMPTY;
                        end else begin
                            busy_q   <= 1'b0;
                            status_q <= ST_SUCCESS;
                            buf_q    <= BUF_FULL;
                        end
                    end else if (thr_hit) begin
                        thr_q <= 1'b1;
                        buf_q <= BUF_HALF;
                    end
                end
            end
        end
    end

    assign busy       = busy_q;
    assign status     = status_q;
    assign buf_status = buf_q;
    assign byte_count = bytes_q;
    assign irq_done   = done_q;
    assign irq_thresh = thr_q;

endmodule

// File: rtl/apb_dma_chan_chk.sv
// Protocol and state checks for apb_dma_chan, attached with bind.
// Assumes: it only observes; stream is the mode bit of the active descriptor.
module apb_dma_chan_chk #(
    parameter int AW     = 32,
    parameter int BC_W   = 20,
    parameter int BEAT_B = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            psel,
    input logic            penable,
    input logic            pready,
    input logic            pwrite,
    input logic [AW-1:0]   paddr,
    input logic            mem_req,
    input logic            busy,
    input logic [1:0]      status,
    input logic [BC_W-1:0] byte_count,
    input logic            irq_done,
    input logic            irq_thresh,
    input logic            stream
);

    // R4
    setup_then_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |=> (psel && penable));

    // R4
    access_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pready) |=> (psel && penable && $stable(paddr) && $stable(pwrite)));

    // R4
    enable_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        penable |-> psel);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!psel && !mem_req));

    // R6
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done);

    // R7
    thresh_stream_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_thresh |-> stream);

    // R9
    aborted_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd1) |-> !busy);

    // R11
    byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
        ((byte_count == $past(byte_count)) || (byte_count == $past(byte_count) + BC_W'(BEAT_B))));

endmodule

bind apb_dma_chan apb_dma_chan_chk #(.AW(AW), .BC_W(BC_W), .BEAT_B(BEAT_B)) chk_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pready(pready),
    .pwrite(pwrite), .paddr(paddr), .mem_req(mem_req), .busy(busy),
    .status(status), .byte_count(byte_count), .irq_done(irq_done),
    .irq_thresh(irq_thresh), .stream(a_cont)
);

// File: tb/apb_dma_chan_tb_top.sv
// Directed bench for apb_dma_chan: memory model with alternating grants,
// APB slave with two wait states, and logs of every completed access.
module apb_dma_chan_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0, cfg_to_mem = 1'b0, cfg_stream = 1'b0;
    logic [4:0]  cfg_req_sel = '0;
    logic [31:0] cfg_mem_addr = '0, cfg_apb_addr = '0;
    logic [15:0] cfg_words = '0;
    logic        abort = 1'b0;
    logic [25:0] periph_req = '1;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        psel, penable, pwrite, pready;
    logic [31:0] paddr, pwdata, prdata;
    logic        busy, irq_done, irq_thresh, next_armed;
    logic [1:0]  status, buf_status;
    logic [19:0] byte_count;

    always #5 clk = ~clk;

    apb_dma_chan dut_i (.*);

    // Bench models and monitors
    logic [31:0] mem_arr [0:127];
    logic [31:0] apb_addr_log [0:63];
    logic [31:0] apb_data_log [0:63];
    logic        apb_wr_log [0:63];
    logic [31:0] mem_addr_log [0:63];
    logic        mem_we_log [0:63];
    int apb_n = 0, mem_n = 0, rd_idx = 0, done_cnt = 0, thr_cnt = 0, thr_at = 0, perr = 0;
    logic [1:0] thr_buf = '0;
    logic gnt_tog = 1'b0;
    logic [1:0] wcnt = '0;
    logic prev_setup = 1'b0, prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;
    int checks = 0, errors = 0;
    bit finished = 0;

    assign mem_gnt   = mem_req && gnt_tog;
    assign mem_rdata = mem_arr[mem_addr[8:2]];
    assign pready    = psel && penable && (wcnt == 2'd2);
    assign prdata    = 32'hA000_0000 + 32'(rd_idx);

    function automatic logic [31:0] seed_word(int i);
        return 32'h5EED_0000 + 32'(i);
    endfunction

    always @(posedge clk) begin
        gnt_tog <= ~gnt_tog;
        wcnt <= (psel && penable && !pready) ? wcnt + 2'd1 : 2'd0;
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem_arr[i] <= seed_word(i);
        end else begin
            if (psel && penable && pready) begin
                apb_addr_log[apb_n[5:0]] <= paddr;
                apb_data_log[apb_n[5:0]] <= pwrite ? pwdata : prdata;
                apb_wr_log[apb_n[5:0]]   <= pwrite;
                apb_n <= apb_n + 1;
                if (!pwrite) rd_idx <= rd_idx + 1;
            end
            if (mem_req && mem_gnt) begin
                mem_addr_log[mem_n[5:0]] <= mem_addr;
                mem_we_log[mem_n[5:0]]   <= mem_we;
                mem_n <= mem_n + 1;
                if (mem_we) mem_arr[mem_addr[8:2]] <= mem_wdata;
            end
            if (irq_done) done_cnt <= done_cnt + 1;
            if (irq_thresh) begin
                thr_cnt <= thr_cnt + 1;
                thr_at  <= apb_n;
                thr_buf <= buf_status;
            end
            if (prev_setup && !(psel && penable)) perr <= perr + 1;
            if (prev_wait && !(psel && penable && paddr == prev_addr)) perr <= perr + 1;
        end
        prev_setup <= psel && !penable;
        prev_wait  <= psel && penable && !pready;
        prev_addr  <= paddr;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic dir, input logic cont, input logic [4:0] sel,
                        input logic [31:0] ma, input logic [31:0] pa, input logic [15:0] n);
        @(negedge clk);
        cfg_to_mem = dir; cfg_stream = cont; cfg_req_sel = sel;
        cfg_mem_addr = ma; cfg_apb_addr = pa; cfg_words = n; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_abort();
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset busy", busy, 0);
        chk("R1 reset status", status, 0);
        chk("R1 reset buf", buf_status, 0);
        chk("R1 reset bytes", byte_count, 0);
        chk("R1 reset bus idle", {psel, mem_req}, 0);
    endtask

    task automatic t_oneshot_tx();
        int a0 = apb_n, m0 = mem_n, d0 = done_cnt, t0 = thr_cnt, p0 = perr;
        load(1'b0, 1'b0, 5'd3, 32'h20, 32'h4000_0010, 16'd4);
        chk("R1 start busy", busy, 1);
        chk("R1 start status", status, 2);
        chk("R1 start buf", buf_status, 0);
        wait_idle();
        chk("R6 word count", apb_n - a0, 4);
        for (int k = 0; k < 4; k++) begin
            chk("R2 apb addr fixed", apb_addr_log[a0 + k], 32'h4000_0010);
            chk("R2 apb write", apb_wr_log[a0 + k], 1);
            chk("R2 apb data", apb_data_log[a0 + k], seed_word(8 + k));
            chk("R2 mem addr", mem_addr_log[m0 + k], 32'h20 + 32'(4 * k));
            chk("R2 mem read", mem_we_log[m0 + k], 0);
        end
        chk("R6 done once", done_cnt - d0, 1);
        chk("R6 no thresh", thr_cnt - t0, 0);
        chk("R6 status success", status, 0);
        chk("R6 buf full", buf_status, 2);
        chk("R11 bytes", byte_count, 16);
        chk("R4 apb phases", perr - p0, 0);
    endtask

    task automatic t_abort_idle();
        pulse_abort();
        @(negedge clk);
        chk("R10 status kept", status, 0);
        chk("R10 busy kept", busy, 0);
        chk("R10 bytes kept", byte_count, 16);
    endtask

    task automatic t_rx();
        int a0 = apb_n, m0 = mem_n, r0 = rd_idx;
        load(1'b1, 1'b0, 5'd7, 32'h80, 32'h4000_0100, 16'd3);
        wait_idle();
        chk("R3 word count", apb_n - a0, 3);
        for (int k = 0; k < 3; k++) begin
            chk("R3 apb addr fixed", apb_addr_log[a0 + k], 32'h4000_0100);
            chk("R3 apb read", apb_wr_log[a0 + k], 0);
            chk("R3 mem addr", mem_addr_log[m0 + k], 32'h80 + 32'(4 * k));
            chk("R3 mem write", mem_we_log[m0 + k], 1);
            chk("R3 mem data", mem_arr[32 + k], 32'hA000_0000 + 32'(r0 + k));
        end
        chk("R3 status", status, 0);
    endtask

    task automatic t_stream();
        int a0 = apb_n, d0 = done_cnt, t0 = thr_cnt;
        load(1'b0, 1'b1, 5'd0, 32'h40, 32'h4000_0020, 16'd6);
        wait_idle();
        chk("R7 thresh once", thr_cnt - t0, 1);
        chk("R7 thresh at half", thr_at - a0, 3);
        chk("R7 buf half", thr_buf, 1);
        chk("R7 done once", done_cnt - d0, 1);
        chk("R7 words", apb_n - a0, 6);
        chk("R11 bytes", byte_count, 24);
    endtask

    task automatic t_gate();
        int a0 = apb_n, m0 = mem_n;
        periph_req = '1;
        periph_req[5] = 1'b0;
        load(1'b0, 1'b0, 5'd5, 32'h20, 32'h4000_0030, 16'd2);
        repeat (40) @(negedge clk);
        chk("R5 line low no beat", (apb_n - a0) + (mem_n - m0), 0);
        chk("R5 still busy", busy, 1);
        periph_req[5] = 1'b1;
        wait_idle();
        chk("R5 runs after line", apb_n - a0, 2);
        a0 = apb_n; m0 = mem_n;
        load(1'b0, 1'b0, 5'd31, 32'h20, 32'h4000_0030, 16'd2);
        repeat (40) @(negedge clk);
        chk("R5 code 31 no beat", (apb_n - a0) + (mem_n - m0), 0);
        chk("R5 code 31 bytes", byte_count, 0);
        pulse_abort();
        chk("R9 idle abort busy", busy, 0);
        chk("R9 idle abort status", status, 1);
    endtask

    task automatic t_handover();
        int a0 = apb_n, d0 = done_cnt;
        bit gap = 0;
        load(1'b0, 1'b0, 5'd2, 32'h20, 32'h4000_0040, 16'd3);
        load(1'b0, 1'b0, 5'd2, 32'hC0, 32'h4000_0200, 16'd2);
        chk("R8 armed", next_armed, 1);
        for (int i = 0; i < 3000 && (apb_n - a0) < 5; i++) begin
            if (!busy) gap = 1;
            @(negedge clk);
        end
        wait_idle();
        chk("R8 no idle gap", gap, 0);
        chk("R8 total words", apb_n - a0, 5);
        for (int k = 0; k < 3; k++)
            chk("R8 first data", apb_data_log[a0 + k], seed_word(8 + k));
        for (int k = 0; k < 2; k++) begin
            chk("R8 second data", apb_data_log[a0 + 3 + k], seed_word(48 + k));
            chk("R8 second addr", apb_addr_log[a0 + 3 + k], 32'h4000_0200);
        end
        chk("R8 done twice", done_cnt - d0, 2);
        chk("R8 bytes carried", byte_count, 20);
        chk("R8 slot cleared", next_armed, 0);
    endtask

    task automatic t_abort_mid();
        int a0 = apb_n, d0 = done_cnt;
        load(1'b0, 1'b0, 5'd1, 32'h20, 32'h4000_0050, 16'd8);
        load(1'b0, 1'b0, 5'd1, 32'hC0, 32'h4000_0060, 16'd2);
        for (int i = 0; i < 3000 && !((apb_n - a0) >= 2 && psel); i++) @(negedge clk);
        pulse_abort();
        wait_idle();
        chk("R9 beat finished", apb_n - a0, 3);
        chk("R9 bytes moved", byte_count, 12);
        chk("R9 status aborted", status, 1);
        chk("R9 not busy", busy, 0);
        chk("R9 no done", done_cnt - d0, 0);
        chk("R9 shadow kept", next_armed, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oneshot_tx();
        t_abort_idle();
        t_rx();
        t_stream();
        t_gate();
        t_handover();
        t_abort_mid();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule